// File: doc/BRIEF.md
# Width-Predicted Sliced Integer Datapath

This block reads two operands from a 64-bit register file and runs them through an ALU. The ALU is cut into four 16-bit significance slices. Before the register read, a prediction is made from the instruction's PC about whether the operands will fit in the lowest slice. When the prediction is narrow, only the lowest slice is clocked for the read and the ALU operation, and the three upper slices stay off.

Each register carries a width tag. The tag is set when the register is written, and it is high when any bit above bit 15 is one. In the read cycle, those tags and the carry or borrow out of the lowest slice show whether the narrow guess was correct. When a narrow guess turns out wrong, the block raises `stall` for one cycle and accepts no new instruction. It then re-reads and re-executes the instruction with all slices on, so the result is always the correct 64-bit value.

A table of 2-bit saturating counters learns each instruction's width from the outcome of its first read.

Top module: `sigslice_datapath`

## Requirements
- R1: The 64-bit datapath is split into four 16-bit slices. Bit k of `slice_en` enables data bits 16k to 16k+15. The three upper enables are always all on or all off together.
- R2: `slice_en[0]` is always 1. When no instruction sits in the read stage, `slice_en` is 4'b0001.
- R3: The predictor holds 64 two-bit counters indexed by PC bits [7:2]. Every counter resets to 2. The prediction is narrow when the counter is 2 or 3. On each instruction's first read, the counter increments (saturating at 3) if the outcome was narrow and decrements (saturating at 0) otherwise.
- R4: In the read cycle, which is the cycle after acceptance, `slice_en` is 4'b0001 for a narrow prediction and 4'b1111 for a wide one.
- R5: The outcome is narrow when both width tags are clear and the lowest slice produces no carry (for add) or borrow (for subtract). A narrow prediction with a wide outcome raises `stall` for exactly one cycle. The next cycle re-reads the operands with `slice_en` = 4'b1111.
- R6: An issue presented while `stall` is high is not accepted, and no result appears in the cycle after a stall. Results leave in issue order.
- R7: `res_valid` rises one cycle after the final read cycle. It carries `res_data` = the 64-bit result and `res_dst` = the issued destination. `iss_op` encodes 0 add, 1 subtract (a-b modulo 2^64), 2 AND, 3 XOR.
- R8: `res_narrow` is 1 exactly when both source values and the result are below 2^16.
- R9: A register write-port update lands at the clock edge and is seen, with its width tag, by later reads.
- R10: After reset, `res_valid` and `stall` are 0 and `slice_en` is 4'b0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Instruction presented |
| iss_pc | input | 32 | Instruction PC, used to index the predictor |
| iss_op | input | 2 | ALU operation code |
| iss_src_a | input | 4 | First source register |
| iss_src_b | input | 4 | Second source register |
| iss_dst | input | 4 | Destination tag carried to the result |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Register write index |
| wr_data | input | 64 | Register write data |
| stall | output | 1 | Width misprediction; issue is held |
| slice_en | output | 4 | Per-slice clock enables for read and ALU |
| res_valid | output | 1 | Result valid |
| res_data | output | 64 | Result value |
| res_dst | output | 4 | Result destination tag |
| res_narrow | output | 1 | Result classified as low-width |

## Verification
Eight register values are swept over every operand pair and all four operations. The values cover zero, one, the largest 16-bit value, values just past 16 bits, all ones, and a value with only a high bit set. This separates narrow operands that stay narrow from additions that carry out of the low slice and subtractions that borrow into the upper slices. Because the same PC is reused across the four operations, each counter is walked up and down, which exposes errors in the prediction, the gating and the stall.

A back-to-back pair checks that an issue held during a stall is taken only after the replay, and that its result follows the stalled instruction's result.

// File: rtl/sigslice_pkg.sv
package sigslice_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_AND = 2'd2,
    OP_XOR = 2'd3
  } alu_op_e;
endpackage

// File: rtl/sigslice_detect.sv
module sigslice_detect #(
  parameter int DATA_W  = 64,
  parameter int SLICE_W = 16
) (
  input  logic [DATA_W-1:0] value,
  output logic              wide
);
  logic unused_low_bits;
  assign unused_low_bits = ^value[SLICE_W-1:0];
  assign wide = |value[DATA_W-1:SLICE_W];
endmodule

// File: rtl/sigslice_lane.sv
module sigslice_lane
  import sigslice_pkg::*;
#(
  parameter int W = 16
) (
  input  logic    en,
  input  alu_op_e op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic    cin,
  output logic [W-1:0] y,
  output logic    cout
);
  logic [W:0]   sum;
  logic [W-1:0] b_x;

  always_comb begin
    b_x = (op == OP_SUB) ? ~b : b;
    sum = {1'b0, a} + {1'b0, b_x} + (W+1)'(cin);
    y    = '0;
    cout = 1'b0;
    if (en) begin
      case (op)
        OP_ADD, OP_SUB: begin
          y    = sum[W-1:0];
          cout = sum[W];
        end
        OP_AND:  y = a & b;
        default: y = a ^ b;
      endcase
    end
  end
endmodule

// File: rtl/sigslice_pred.sv
module sigslice_pred #(
  parameter int         DEPTH = 64,
  parameter logic [1:0] INIT  = 2'd2,
  localparam int        IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] lk_idx,
  output logic             lk_narrow,
  input  logic             up_en,
  input  logic [IDX_W-1:0] up_idx,
  input  logic             up_narrow
);
  logic [1:0] ctr [DEPTH];

  assign lk_narrow = ctr[lk_idx] >= 2'd2;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) ctr[i] <= INIT;
    end else if (up_en) begin
      if (up_narrow && ctr[up_idx] != 2'd3)
        ctr[up_idx] <= ctr[up_idx] + 2'd1;
      else if (!up_narrow && ctr[up_idx] != 2'd0)
        ctr[up_idx] <= ctr[up_idx] - 2'd1;
    end
  end
endmodule

// File: rtl/sigslice_datapath.sv
module sigslice_datapath
  import sigslice_pkg::*;
#(
  parameter int  DATA_W     = 64,
  parameter int  SLICE_W    = 16,
  parameter int  NREGS      = 16,
  parameter int  PRED_DEPTH = 64,
  parameter int  PC_W       = 32,
  localparam int NSLICE     = DATA_W / SLICE_W,
  localparam int RIDX_W     = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              iss_valid,
  input  logic [PC_W-1:0]   iss_pc,
  input  logic [1:0]        iss_op,
  input  logic [RIDX_W-1:0] iss_src_a,
  input  logic [RIDX_W-1:0] iss_src_b,
  input  logic [RIDX_W-1:0] iss_dst,
  input  logic              wr_en,
  input  logic [RIDX_W-1:0] wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  output logic              stall,
  output logic [NSLICE-1:0] slice_en,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data,
  output logic [RIDX_W-1:0] res_dst,
  output logic              res_narrow
);
  localparam int PIDX_W = $clog2(PRED_DEPTH);

  // register file: value plus width tag in the top bit
  logic [DATA_W:0] rf_mem [NREGS];
  logic            wr_wide;

  sigslice_detect #(.DATA_W(DATA_W), .SLICE_W(SLICE_W)) u_wr_detect (
    .value (wr_data),
    .wide  (wr_wide)
  );

  always_ff @(posedge clk) begin
    if (wr_en) rf_mem[wr_idx] <= {wr_wide, wr_data};
  end

  // read stage registers
  logic              v1, replay1, pred1;
  logic [PIDX_W-1:0] pidx1;
  alu_op_e           op1;
  logic [RIDX_W-1:0] a1, b1, dst1;

  logic [PIDX_W-1:0] iss_pidx;
  logic              lk_narrow;
  logic              unused_pc_bits;
  assign iss_pidx       = iss_pc[PIDX_W+1:2];
  assign unused_pc_bits = ^{iss_pc[PC_W-1:PIDX_W+2], iss_pc[1:0]};

  logic mispredict, narrow_act, spill;

  sigslice_pred #(.DEPTH(PRED_DEPTH), .INIT(2'd2)) u_pred (
    .clk       (clk),
    .rst       (rst),
    .lk_idx    (iss_pidx),
    .lk_narrow (lk_narrow),
    .up_en     (v1 && !replay1),
    .up_idx    (pidx1),
    .up_narrow (narrow_act)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      v1      <= 1'b0;
      replay1 <= 1'b0;
      pred1   <= 1'b0;
      pidx1   <= '0;
      op1     <= OP_ADD;
      a1      <= '0;
      b1      <= '0;
      dst1    <= '0;
    end else if (mispredict) begin
      replay1 <= 1'b1;
    end else begin
      v1      <= iss_valid;
      replay1 <= 1'b0;
      if (iss_valid) begin
        pred1 <= lk_narrow;
        pidx1 <= iss_pidx;
        op1   <= alu_op_e'(iss_op);
        a1    <= iss_src_a;
        b1    <= iss_src_b;
        dst1  <= iss_dst;
      end
    end
  end

  // slice enables: the lowest slice is always on
  logic upper_on;
  assign upper_on = v1 && !(pred1 && !replay1);
  assign slice_en = {{(NSLICE-1){upper_on}}, 1'b1};

  logic [DATA_W:0]   rd_a, rd_b;
  logic [DATA_W-1:0] alu_y;
  logic [NSLICE:0]   carry;
  assign rd_a     = rf_mem[a1];
  assign rd_b     = rf_mem[b1];
  assign carry[0] = (op1 == OP_SUB);

  for (genvar s = 0; s < NSLICE; s++) begin : g_slice
    sigslice_lane #(.W(SLICE_W)) u_lane (
      .en   (slice_en[s]),
      .op   (op1),
      .a    (rd_a[s*SLICE_W +: SLICE_W]),
      .b    (rd_b[s*SLICE_W +: SLICE_W]),
      .cin  (carry[s]),
      .y    (alu_y[s*SLICE_W +: SLICE_W]),
      .cout (carry[s+1])
    );
  end

  // significance check from the width tags and the low-slice spill
  always_comb begin
    case (op1)
      OP_ADD:  spill = carry[1];
      OP_SUB:  spill = !carry[1];
      default: spill = 1'b0;
    endcase
  end

  assign narrow_act = !rd_a[DATA_W] && !rd_b[DATA_W] && !spill;
  assign mispredict = v1 && pred1 && !replay1 && !narrow_act;
  assign stall      = mispredict;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid  <= 1'b0;
      res_data   <= '0;
      res_dst    <= '0;
      res_narrow <= 1'b0;
    end else begin
      res_valid <= v1 && !mispredict;
      if (v1 && !mispredict) begin
        res_data   <= alu_y;
        res_dst    <= dst1;
        res_narrow <= narrow_act;
      end
    end
  end
endmodule

// File: rtl/sigslice_checker.sv
module sigslice_checker #(
  parameter int  DATA_W  = 64,
  parameter int  SLICE_W = 16,
  localparam int NSLICE  = DATA_W / SLICE_W
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      stall,
  input logic [NSLICE-1:0]         slice_en,
  input logic                      res_valid,
  input logic                      res_narrow,
  input logic [DATA_W-SLICE_W-1:0] res_hi
);
  AST_LOW_SLICE_ON: assert property (@(posedge clk) disable iff (rst)
    slice_en[0]); // R2

  AST_UPPER_TOGETHER: assert property (@(posedge clk) disable iff (rst)
    (slice_en[NSLICE-1:1] == '0) || (slice_en[NSLICE-1:1] == '1)); // R1

  AST_STALL_GATED: assert property (@(posedge clk) disable iff (rst)
    stall |-> slice_en[NSLICE-1:1] == '0); // R4

  AST_STALL_REPLAY: assert property (@(posedge clk) disable iff (rst)
    stall |=> !stall && slice_en == '1); // R5

  AST_NO_RESULT_AFTER_STALL: assert property (@(posedge clk) disable iff (rst)
    stall |=> !res_valid); // R6

  AST_NARROW_FITS: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_narrow) |-> res_hi == '0); // R8
endmodule

bind sigslice_datapath sigslice_checker #(.DATA_W(DATA_W), .SLICE_W(SLICE_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .stall      (stall),
  .slice_en   (slice_en),
  .res_valid  (res_valid),
  .res_narrow (res_narrow),
  .res_hi     (res_data[DATA_W-1:SLICE_W])
);

// File: tb/sigslice_datapath_bench.sv
module sigslice_datapath_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        iss_valid = 1'b0;
  logic [31:0] iss_pc = '0;
  logic [1:0]  iss_op = '0;
  logic [3:0]  iss_src_a = '0, iss_src_b = '0, iss_dst = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [63:0] wr_data = '0;
  logic        stall;
  logic [3:0]  slice_en;
  logic        res_valid;
  logic [63:0] res_data;
  logic [3:0]  res_dst;
  logic        res_narrow;

  always #5 clk = ~clk;

  sigslice_datapath u_sigslice_datapath (
    .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_pc(iss_pc), .iss_op(iss_op),
    .iss_src_a(iss_src_a), .iss_src_b(iss_src_b), .iss_dst(iss_dst),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .stall(stall), .slice_en(slice_en), .res_valid(res_valid), .res_data(res_data),
    .res_dst(res_dst), .res_narrow(res_narrow)
  );

  int n_chk = 0, n_bad = 0, n_mis = 0, n_stall = 0;
  logic [63:0] regv [16];
  int          ctr [64];

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_alu(input logic [1:0] op, input logic [63:0] a, input logic [63:0] b);
    case (op)
      2'd0:    return a + b;
      2'd1:    return a - b;
      2'd2:    return a & b;
      default: return a ^ b;
    endcase
  endfunction

  function automatic bit is_narrow(input logic [63:0] a, input logic [63:0] b, input logic [63:0] y);
    return (a < 64'h10000) && (b < 64'h10000) && (y < 64'h10000);
  endfunction

  task automatic train(input int k, input bit nar);
    if (nar && ctr[k] < 3) ctr[k]++;
    else if (!nar && ctr[k] > 0) ctr[k]--;
  endtask

  task automatic wreg(input int idx, input logic [63:0] val);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'(idx); wr_data = val;
    @(negedge clk);
    wr_en = 1'b0;
    regv[idx] = val;
  endtask

  task automatic run(input logic [31:0] pc, input int ra, input int rb, input logic [1:0] op, input int dst);
    logic [63:0] y;
    bit nar, pn;
    int k;
    y   = ref_alu(op, regv[ra], regv[rb]);
    nar = is_narrow(regv[ra], regv[rb], y);
    k   = int'(pc[7:2]);
    pn  = ctr[k] >= 2;
    @(negedge clk);
    iss_valid = 1'b1; iss_pc = pc; iss_op = op;
    iss_src_a = 4'(ra); iss_src_b = 4'(rb); iss_dst = 4'(dst);
    @(negedge clk);
    iss_valid = 1'b0;
    check("R4 slice_en in read cycle", 64'(slice_en), pn ? 64'h1 : 64'hF);
    check("R5 stall on width miss", 64'(stall), 64'(pn && !nar));
    if (pn && !nar) begin
      n_mis++; n_stall++;
      @(negedge clk);
      check("R5 replay slice_en", 64'(slice_en), 64'hF);
      check("R6 no result during replay", 64'(res_valid), 64'h0);
    end
    @(negedge clk);
    check("R7 res_valid", 64'(res_valid), 64'h1);
    check("R7 res_data", res_data, y);
    check("R7 res_dst", 64'(res_dst), 64'(dst));
    check("R8 res_narrow", 64'(res_narrow), 64'(nar));
    train(k, nar);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] vals [8];
    logic [63:0] ya, yb;
    bit pb;
    vals[0] = 64'h0;                    vals[1] = 64'h1;
    vals[2] = 64'hFFFF;                 vals[3] = 64'h7FFF;
    vals[4] = 64'h1_0000;               vals[5] = 64'hFFFF_FFFF_FFFF_FFFF;
    vals[6] = 64'h8000_0000_0000_0000;  vals[7] = 64'h0000_0001_0000_0005;
    for (int i = 0; i < 64; i++) ctr[i] = 2;
    for (int i = 0; i < 16; i++) regv[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check("R10 res_valid after reset", 64'(res_valid), 64'h0);
    check("R10 stall after reset", 64'(stall), 64'h0);
    check("R10 slice_en after reset (R2 idle)", 64'(slice_en), 64'h1);

    // R9 register writes
    for (int i = 0; i < 8; i++) wreg(i, vals[i]);

    // R1 R3 R4 R5 R7 R8 full sweep; op inner so each counter walks
    for (int ra = 0; ra < 8; ra++)
      for (int rb = 0; rb < 8; rb++)
        for (int op = 0; op < 4; op++)
          run(32'((ra * 8 + rb) * 4), ra, rb, 2'(op), (ra + rb + op) % 16);

    // R3 aliasing: PC bits above [7:2] ignored
    run(32'h0000_0100, 2, 3, 2'd2, 9);
    run(32'hABCD_0300, 5, 1, 2'd0, 10);

    // R9 overwrite changes the width tag
    wreg(7, 64'h0000_0000_0000_0042);
    run(32'h0000_00FC, 7, 1, 2'd0, 11);
    wreg(7, 64'h0000_0004_0000_0000);
    run(32'h0000_00FC, 7, 1, 2'd0, 12);

    // R6 back-to-back: hold an issue across a stall
    run(32'h0000_0400, 1, 1, 2'd2, 1);
    run(32'h0000_0400, 1, 1, 2'd2, 1);
    ya = ref_alu(2'd3, regv[5], regv[0]);
    yb = ref_alu(2'd0, regv[1], regv[1]);
    @(negedge clk);
    iss_valid = 1'b1; iss_pc = 32'h400; iss_op = 2'd3;
    iss_src_a = 4'd5; iss_src_b = 4'd0; iss_dst = 4'd13;
    @(negedge clk);
    check("R5 stall for held pair", 64'(stall), 64'h1);
    n_mis++; n_stall++;
    train(0, 1'b0);
    iss_pc = 32'h404; iss_op = 2'd0;
    iss_src_a = 4'd1; iss_src_b = 4'd1; iss_dst = 4'd14;
    pb = ctr[1] >= 2;
    @(negedge clk);
    check("R6 no result while issue held", 64'(res_valid), 64'h0);
    check("R5 replay enables held pair", 64'(slice_en), 64'hF);
    @(negedge clk);
    iss_valid = 1'b0;
    check("R6 first result in order", res_data, ya);
    check("R6 first dst in order", 64'(res_dst), 64'd13);
    check("R4 held issue prediction", 64'(slice_en), pb ? 64'h1 : 64'hF);
    @(negedge clk);
    check("R6 held issue result", res_data, yb);
    check("R6 held issue dst", 64'(res_dst), 64'd14);
    train(1, 1'b1);
    @(negedge clk);
    check("R2 idle slice_en", 64'(slice_en), 64'h1);

    $display("mispredictions %0d, stall cycles %0d", n_mis, n_stall);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule